// File: doc/BRIEF.md
# Busy Gating for Remote-Terminal Command Responses

This block sits between the command decoder and the message engine of a remote terminal on a command/response serial bus. For every command that the decoder flags as valid, it decides, one clock later, whether the message engine may touch message RAM and whether the discrete output pulses that follow a command may be issued. A status response is always permitted, so the terminal answers every valid command even while the host has declared it busy.

A subset of mode commands ignores the busy condition for RAM access. These are the status, last-command, terminal-reset and the two transmitter-shutdown commands, plus any reserved mode code that the decoder reports as enabled by configuration. Output pulses are suppressed for every command while busy, except the pulse that follows a terminal-reset mode command. The block also keeps a latched busy flag. Reset sets this flag. It is cleared by the first command that is not a status or last-command request, or by a host clear strobe.

The latched flag is held by a two-state machine. In state `LB_AWAIT` the flag reads 1. The `CMD_RELEASE` transition moves to `LB_CLEAR` on a valid command outside the two excluded codes. The `HOST_RELEASE` transition moves to `LB_CLEAR` on a host clear strobe. `LB_CLEAR` holds, with the flag at 0, until reset returns the machine to `LB_AWAIT`.

Top module: `busy_gate`

## Requirements
- R1: One cycle after every clock edge with `cmd_valid`=1, `resp_valid` is 1 for exactly one cycle, whatever the value of `busy`. It is 0 in every other cycle.
- R2: With `busy`=0, every valid command gives `ram_en`=1 and `pulse_en`=1 in the same cycle as `resp_valid`.
- R3: A command is a mode command when `cmd_subaddr` is 5'b00000 or 5'b11111. With `busy`=1, a valid command that is not exempt gives `ram_en`=0.
- R4: With `busy`=1, a mode command with `cmd_mode` equal to 5'b00010 (status), 5'b10010 (last command), 5'b01000 (terminal reset), 5'b00100 (shutdown) or 5'b00101 (override shutdown) still gives `ram_en`=1.
- R5: With `busy`=1, a mode command with `rsvd_legal`=1 gives `ram_en`=1. `rsvd_legal` has no effect on a command that is not a mode command.
- R6: With `busy`=1, `pulse_en` is 0 for every command.
- R7: `rst_pulse` is 1 one cycle after a valid mode command with code 5'b01000, whatever the value of `busy`. It is 0 after every other command.
- R8: While `rst_n`=0 and in the first cycle after it, `busy_latched`=1 and `resp_valid`, `ram_en`, `pulse_en` and `rst_pulse` are 0.
- R9: While `busy_latched`=1, a valid command other than a mode command with code 5'b00010 or 5'b10010 makes `busy_latched` 0 in the next cycle. The two excluded commands leave it at 1.
- R10: `host_clr`=1 at a clock edge makes `busy_latched` 0 in the next cycle.
- R11: Once `busy_latched` is 0 it stays 0 until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_valid | input | 1 | One-cycle strobe for a validly received command |
| cmd_subaddr | input | 5 | Subaddress field of the command |
| cmd_mode | input | 5 | Mode-code / word-count field of the command |
| rsvd_legal | input | 1 | Decoder flag: reserved mode code enabled by configuration |
| busy | input | 1 | Host-controlled busy condition |
| host_clr | input | 1 | Host strobe that clears the latched busy flag |
| resp_valid | output | 1 | Status response permitted for the last command |
| ram_en | output | 1 | Message RAM access permitted for the last command |
| pulse_en | output | 1 | Discrete output pulses permitted for the last command |
| rst_pulse | output | 1 | Terminal-reset pulse after a reset mode command |
| busy_latched | output | 1 | Latched busy flag |

## Verification
The assertions assume that `busy`, `rsvd_legal` and the command fields are steady around the clock edge at which `cmd_valid` is sampled. They also assume that `cmd_valid` lasts a single cycle per command, although back-to-back strobes are legal. The bench drives every input at the falling edge, so each value is settled a half period before it is sampled. Random commands are weighted toward the two mode subaddresses and the listed codes, so that exempt, excluded and plain commands all occur under both busy values. Resets are applied in mid-run to re-arm the latched flag.

// File: rtl/busy_gate_pkg.sv
package busy_gate_pkg;

    localparam int SA_W = 5;
    localparam int MC_W = 5;

    localparam logic [SA_W-1:0] SA_MODE_LO = '0;
    localparam logic [SA_W-1:0] SA_MODE_HI = '1;

    localparam logic [MC_W-1:0] MC_TX_STATUS = 5'b00010;
    localparam logic [MC_W-1:0] MC_TX_LASTCMD = 5'b10010;
    localparam logic [MC_W-1:0] MC_RT_RESET = 5'b01000;
    localparam logic [MC_W-1:0] MC_TX_SHUT = 5'b00100;
    localparam logic [MC_W-1:0] MC_TX_OVRD = 5'b00101;

    localparam int N_EXEMPT = 5;

    typedef enum logic [0:0] {
        LB_AWAIT = 1'b0,
        LB_CLEAR = 1'b1
    } lb_state_t;

    typedef struct packed {
        logic is_mode;
        logic exempt;
        logic keeps_busy;
        logic is_reset;
    } cmd_class_t;

    function automatic logic [MC_W-1:0] exempt_code(input int idx);
        unique case (idx)
            0:       return MC_TX_STATUS;
            1:       return MC_TX_LASTCMD;
            2:       return MC_RT_RESET;
            3:       return MC_TX_SHUT;
            default: return MC_TX_OVRD;
        endcase
    endfunction

endpackage

// File: rtl/bg_classify.sv
module bg_classify
    import busy_gate_pkg::*;
(
    input  logic [SA_W-1:0] subaddr,
    input  logic [MC_W-1:0] mode,
    input  logic            rsvd_legal,
    output cmd_class_t      cls
);
    logic [N_EXEMPT-1:0] hit;
    logic                mode_sa;

    assign mode_sa = (subaddr == SA_MODE_LO) || (subaddr == SA_MODE_HI);

    for (genvar g = 0; g < N_EXEMPT; g++) begin : g_exempt
        assign hit[g] = (mode == exempt_code(g));
    end

    always_comb begin
        cls.is_mode    = mode_sa;
        cls.exempt     = mode_sa && ((|hit) || rsvd_legal);
        cls.keeps_busy = mode_sa && ((mode == MC_TX_STATUS) || (mode == MC_TX_LASTCMD));
        cls.is_reset   = mode_sa && (mode == MC_RT_RESET);
    end
endmodule

// File: rtl/bg_gate.sv
module bg_gate
    import busy_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       busy,
    input  cmd_class_t cls,
    output logic       resp_valid,
    output logic       ram_en,
    output logic       pulse_en,
    output logic       rst_pulse
);
    logic ram_d, pulse_d, rstp_d;

    always_comb begin
        ram_d   = cmd_valid && (!busy || cls.exempt);
        pulse_d = cmd_valid && !busy;
        rstp_d  = cmd_valid && cls.is_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            ram_en     <= 1'b0;
            pulse_en   <= 1'b0;
            rst_pulse  <= 1'b0;
        end else begin
            resp_valid <= cmd_valid;
            ram_en     <= ram_d;
            pulse_en   <= pulse_d;
            rst_pulse  <= rstp_d;
        end
    end
endmodule

// File: rtl/bg_busy_fsm.sv
module bg_busy_fsm
    import busy_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic keeps_busy,
    input  logic host_clr,
    output logic busy_latched
);
    lb_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LB_AWAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LB_AWAIT: begin
                if (host_clr)                      state_nx = LB_CLEAR; // HOST_RELEASE
                else if (cmd_valid && !keeps_busy) state_nx = LB_CLEAR; // CMD_RELEASE
            end
            LB_CLEAR: state_nx = LB_CLEAR;
            default:  state_nx = LB_AWAIT;
        endcase
    end

    always_comb begin
        unique case (state)
            LB_AWAIT: busy_latched = 1'b1;
            LB_CLEAR: busy_latched = 1'b0;
            default:  busy_latched = 1'b1;
        endcase
    end
endmodule

// File: rtl/busy_gate.sv
module busy_gate
    import busy_gate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [SA_W-1:0] cmd_subaddr,
    input  logic [MC_W-1:0] cmd_mode,
    input  logic            rsvd_legal,
    input  logic            busy,
    input  logic            host_clr,
    output logic            resp_valid,
    output logic            ram_en,
    output logic            pulse_en,
    output logic            rst_pulse,
    output logic            busy_latched
);
    cmd_class_t cls;

    bg_classify i_cls (
        .subaddr    (cmd_subaddr),
        .mode       (cmd_mode),
        .rsvd_legal (rsvd_legal),
        .cls        (cls)
    );

    bg_gate i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .busy       (busy),
        .cls        (cls),
        .resp_valid (resp_valid),
        .ram_en     (ram_en),
        .pulse_en   (pulse_en),
        .rst_pulse  (rst_pulse)
    );

    bg_busy_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .keeps_busy   (cls.keeps_busy),
        .host_clr     (host_clr),
        .busy_latched (busy_latched)
    );
endmodule

// File: rtl/busy_gate_checker.sv
module busy_gate_checker
    import busy_gate_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [SA_W-1:0] cmd_subaddr,
    input logic [MC_W-1:0] cmd_mode,
    input logic            rsvd_legal,
    input logic            busy,
    input logic            host_clr,
    input logic            resp_valid,
    input logic            ram_en,
    input logic            pulse_en,
    input logic            rst_pulse,
    input logic            busy_latched
);
    logic mode_sa;
    assign mode_sa = (cmd_subaddr == '0) || (cmd_subaddr == '1);

    assert_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> resp_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !resp_valid && !ram_en && !pulse_en && !rst_pulse);
    assert_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> ram_en && pulse_en);
    assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy && !mode_sa |=> !ram_en);
    assert_exempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy && mode_sa && (cmd_mode == 5'b00010) |=> ram_en);
    assert_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy && mode_sa && rsvd_legal |=> ram_en);
    assert_nopulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy |=> !pulse_en);
    assert_rstpulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && mode_sa && (cmd_mode == 5'b01000) |=> rst_pulse);
    assert_rstonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> resp_valid);
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_latched) |-> $past(cmd_valid || host_clr));
    assert_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> !busy_latched);
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_latched |=> !busy_latched);
endmodule

bind busy_gate busy_gate_checker i_busy_gate_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_subaddr  (cmd_subaddr),
    .cmd_mode     (cmd_mode),
    .rsvd_legal   (rsvd_legal),
    .busy         (busy),
    .host_clr     (host_clr),
    .resp_valid   (resp_valid),
    .ram_en       (ram_en),
    .pulse_en     (pulse_en),
    .rst_pulse    (rst_pulse),
    .busy_latched (busy_latched)
);

// File: tb/test_busy_gate.sv
module test_busy_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd_subaddr = '0;
    logic [4:0] cmd_mode = '0;
    logic       rsvd_legal = 1'b0;
    logic       busy = 1'b0;
    logic       host_clr = 1'b0;
    logic       resp_valid, ram_en, pulse_en, rst_pulse, busy_latched;

    int n_chk = 0;
    int n_fail = 0;
    logic m_lat = 1'b1;
    bit done = 0;

    always #2 clk = ~clk;

    busy_gate i_busy_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_subaddr(cmd_subaddr),
        .cmd_mode(cmd_mode), .rsvd_legal(rsvd_legal), .busy(busy), .host_clr(host_clr),
        .resp_valid(resp_valid), .ram_en(ram_en), .pulse_en(pulse_en),
        .rst_pulse(rst_pulse), .busy_latched(busy_latched)
    );

    function automatic bit f_mode(input logic [4:0] sa);
        return (sa == 5'b00000) || (sa == 5'b11111);
    endfunction

    function automatic bit f_exempt(input logic [4:0] sa, input logic [4:0] mc, input logic rl);
        if (!f_mode(sa)) return 0;
        return rl || mc == 5'b00010 || mc == 5'b10010 || mc == 5'b01000 ||
               mc == 5'b00100 || mc == 5'b00101;
    endfunction

    function automatic bit f_keep(input logic [4:0] sa, input logic [4:0] mc);
        return f_mode(sa) && (mc == 5'b00010 || mc == 5'b10010);
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, check after the next rising edge
    task automatic step(input logic v, input logic [4:0] sa, input logic [4:0] mc,
                        input logic rl, input logic b, input logic hc, input string req);
        bit e_ram, e_pul, e_rst;
        cmd_valid = v; cmd_subaddr = sa; cmd_mode = mc; rsvd_legal = rl;
        busy = b; host_clr = hc;
        e_ram = v && (!b || f_exempt(sa, mc, rl));
        e_pul = v && !b;
        e_rst = v && f_mode(sa) && mc == 5'b01000;
        if (hc || (v && !f_keep(sa, mc))) m_lat = 1'b0;
        @(negedge clk);
        check(req, "resp_valid (R1)", resp_valid, v);
        check(req, "ram_en (R2/R3/R4/R5)", ram_en, e_ram);
        check(req, "pulse_en (R2/R6)", pulse_en, e_pul);
        check(req, "rst_pulse (R7)", rst_pulse, e_rst);
        check(req, "busy_latched (R9/R10/R11)", busy_latched, m_lat);
    endtask

    task automatic do_reset();
        cmd_valid = 0; host_clr = 0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", "busy_latched in reset", busy_latched, 1'b1);
        check("R8", "resp_valid in reset", resp_valid, 1'b0);
        check("R8", "ram_en in reset", ram_en, 1'b0);
        rst_n = 1'b1;
        m_lat = 1'b1;
        @(negedge clk);
        check("R8", "busy_latched after reset", busy_latched, 1'b1);
        check("R8", "pulse_en after reset", pulse_en, 1'b0);
        check("R8", "rst_pulse after reset", rst_pulse, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h1553_0b5));
        @(negedge clk);
        do_reset();
        // R9: excluded commands keep the latched flag
        step(1, 5'b00000, 5'b00010, 0, 1, 0, "R9 status keeps");
        step(1, 5'b11111, 5'b10010, 0, 1, 0, "R9 lastcmd keeps");
        step(0, 5'b00000, 5'b00000, 0, 1, 0, "R1 idle");
        step(1, 5'b00011, 5'b00010, 0, 1, 0, "R9 data cmd releases, R3 blocked");
        step(1, 5'b00000, 5'b01000, 0, 1, 0, "R7 reset pulse under busy, R4");
        step(1, 5'b11111, 5'b00100, 0, 1, 0, "R4 shutdown");
        step(1, 5'b11111, 5'b00101, 0, 1, 0, "R4 override");
        step(1, 5'b00000, 5'b10111, 1, 1, 0, "R5 legal reserved");
        step(1, 5'b00000, 5'b10111, 0, 1, 0, "R3 reserved not legal");
        step(1, 5'b01010, 5'b00000, 1, 1, 0, "R5 rsvd_legal ignored off mode");
        step(1, 5'b01010, 5'b01000, 0, 0, 0, "R2 free, R7 no pulse off mode");
        step(1, 5'b00000, 5'b00010, 0, 0, 0, "R11 stays clear");
        do_reset();
        step(0, 5'b00000, 5'b00000, 0, 1, 1, "R10 host clear");
        step(1, 5'b00000, 5'b00010, 0, 1, 0, "R11 stays clear");
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] sa, mc;
            int r;
            r = $urandom_range(0, 9);
            sa = (r < 4) ? 5'b00000 : (r < 7) ? 5'b11111 : 5'($urandom);
            r = $urandom_range(0, 9);
            mc = (r == 0) ? 5'b00010 : (r == 1) ? 5'b10010 : (r == 2) ? 5'b01000 :
                 (r == 3) ? 5'b00100 : (r == 4) ? 5'b00101 : 5'($urandom);
            step($urandom_range(0, 3) != 0 && ($urandom_range(0, 7) != 0 || !m_lat),
                 sa, mc, 1'($urandom), 1'($urandom), $urandom_range(0, 40) == 0,
                 "R1-random");
            if ($urandom_range(0, 150) == 0) do_reset();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule